// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

A synchronous single-port memory of 36-bit words split into four 9-bit byte lanes. Every address, control and write-data input is captured in an input register on the rising clock; the read word passes through one output register. An access is opened by either of two address strobes. The processor strobe always opens a read, and any write it leads to lands on the next cycle. The controller strobe can open a read or finish a write in its own cycle. A 2-bit wrapping burst counter steps the two low address bits through a linear or an interleaved order.

The bidirectional data bus is replaced by a read-data output and a drive flag. The flag marks the cycles in which the bus would be driven. It is held low during write cycles, in the first cycle after a deselected state, and from the edge that registers a deselect. It is also gated combinationally by an active-low output enable. The depth is set by `ADDR_W`: 15 gives 32768 words, and the default of 10 keeps elaboration small.

Top module: `pbsram_top`

## Requirements
- R1: Read data for an address registered at clock edge t appears on `rd_data_o` after edge t+1.
- R2: A cycle with `pstrb_n_i` low and `sel_a_n_i` low starts a read whatever the write inputs show, and writes nothing. A write on the next cycle with no strobe and `burst_step_n_i` high goes to that same address.
- R3: With `cstrb_n_i` low, `pstrb_n_i` high and the chip selected, a write completes in that cycle at the presented address, and `burst_step_n_i` is ignored.
- R4: With `wr_all_n_i` low, all four lanes are written, regardless of `byte_wr_n_i` and `lane_sel_n_i`.
- R5: With `wr_all_n_i` high and `byte_wr_n_i` low, only lane k (bits [9k+8:9k]) whose `lane_sel_n_i[k]` is low is written, and the other lanes keep their contents. If all four selects are high, the cycle is a read.
- R6: `rd_drive_o` is low in every cycle that registers a write, even with `out_en_n_i` low.
- R7: In the first cycle of an access that follows a deselected state, `rd_drive_o` is low.
- R8: When a strobe is registered while the chip enables are not all active, the chip is deselected and `rd_drive_o` is low from that edge on.
- R9: The chip is selected only when `sel_a_n_i` is low, `sel_b_i` is high and `sel_c_n_i` is low. `pstrb_n_i` is ignored while `sel_a_n_i` is high.
- R10: With `seq_linear_i` high, burst position n uses low bits (first + n) mod 4. `burst_step_n_i` low advances the position and high holds it.
- R11: With `seq_linear_i` low, burst position n uses low bits first XOR n.
- R12: `rd_drive_o` is high when a read was registered at the previous edge, a read is registered now, and `out_en_n_i` is low. It follows `out_en_n_i` without a clock.
- R13: During and just after reset, `rd_drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wr_data_i | input | 36 | Write data, four 9-bit lanes |
| pstrb_n_i | input | 1 | Processor address strobe, active low |
| cstrb_n_i | input | 1 | Controller address strobe, active low |
| burst_step_n_i | input | 1 | Burst advance, active low |
| sel_a_n_i | input | 1 | Chip enable A, active low |
| sel_b_i | input | 1 | Chip enable B, active high |
| sel_c_n_i | input | 1 | Chip enable C, active low |
| wr_all_n_i | input | 1 | Write all lanes, active low |
| byte_wr_n_i | input | 1 | Lane write enable, active low |
| lane_sel_n_i | input | 4 | Per-lane write selects, active low |
| out_en_n_i | input | 1 | Output enable, asynchronous, active low |
| seq_linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| rd_data_o | output | 36 | Registered read data |
| rd_drive_o | output | 1 | Bus-drive flag for read data |

## Verification
Several properties are checked on every clock. A processor-strobe start never enables a lane write. The all-lanes and per-lane write patterns match the registered write inputs. The drive flag stays low in write cycles, after a deselect, and in the first cycle after a deselected state. The burst counter clears on load and holds when not stepped. Only the bench's scenarios can show the full data path, against a reference memory. They cover byte-merge contents after mixed-lane writes, both burst orders wrapping inside an aligned group of four, and the two-cycle processor-strobe write landing at the right address. They also cover a processor strobe being ignored while chip enable A is inactive.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  localparam int LANE_W_DEF = 9;
  localparam int LANES_DEF  = 4;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/pbsram_burst.sv
module pbsram_burst (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  logic       linear_i,
  input  logic [1:0] first_i,
  output logic [1:0] lo_o
);
  logic [1:0] first_q, cnt_q, first_n, cnt_n;

  always_comb begin
    first_n = load_i ? first_i : first_q;
    cnt_n   = load_i ? 2'd0 : cnt_q + {1'b0, step_i};
    lo_o    = linear_i ? first_n + cnt_n : first_n ^ cnt_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 2'd0;
      cnt_q   <= 2'd0;
    end else begin
      first_q <= first_n;
      cnt_q   <= cnt_n;
    end
  end

  assert_load_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == 2'd0));
  assert_hold_without_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pbsram_lane_dec.sv
module pbsram_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             allow_i,
  input  logic             all_n_i,
  input  logic             byte_n_i,
  input  logic [LANES-1:0] sel_n_i,
  output logic             any_o,
  output logic [LANES-1:0] we_o
);
  assign any_o = ~all_n_i | (~byte_n_i & ~(&sel_n_i));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign we_o[k] = allow_i & (~all_n_i | (~byte_n_i & ~sel_n_i[k]));
  end
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      re_i,
  input  logic [LANES-1:0]          we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANE_W*LANES-1:0]   wdata_i,
  output logic [LANE_W*LANES-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i)    rd_q        <= mem[addr_i];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/pbsram_top.sv
module pbsram_top
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = LANE_W_DEF,
  parameter int LANES  = LANES_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANE_W*LANES-1:0] wr_data_i,
  input  logic                    pstrb_n_i,
  input  logic                    cstrb_n_i,
  input  logic                    burst_step_n_i,
  input  logic                    sel_a_n_i,
  input  logic                    sel_b_i,
  input  logic                    sel_c_n_i,
  input  logic                    wr_all_n_i,
  input  logic                    byte_wr_n_i,
  input  logic [LANES-1:0]        lane_sel_n_i,
  input  logic                    out_en_n_i,
  input  logic                    seq_linear_i,
  output logic [LANE_W*LANES-1:0] rd_data_o,
  output logic                    rd_drive_o
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int BASE_W = ADDR_W - 2;

  // input register stage
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic              r_ps_n, r_cs_n, r_st_n, r_sa_n, r_sb, r_sc_n, r_ga_n, r_bw_n, r_lin;
  logic [LANES-1:0]  r_ls_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_addr  <= '0;
      r_wdata <= '0;
      r_ps_n  <= 1'b1;
      r_cs_n  <= 1'b1;
      r_st_n  <= 1'b1;
      r_sa_n  <= 1'b1;
      r_sb    <= 1'b0;
      r_sc_n  <= 1'b1;
      r_ga_n  <= 1'b1;
      r_bw_n  <= 1'b1;
      r_ls_n  <= '1;
      r_lin   <= 1'b0;
    end else begin
      r_addr  <= addr_i;
      r_wdata <= wr_data_i;
      r_ps_n  <= pstrb_n_i;
      r_cs_n  <= cstrb_n_i;
      r_st_n  <= burst_step_n_i;
      r_sa_n  <= sel_a_n_i;
      r_sb    <= sel_b_i;
      r_sc_n  <= sel_c_n_i;
      r_ga_n  <= wr_all_n_i;
      r_bw_n  <= byte_wr_n_i;
      r_ls_n  <= lane_sel_n_i;
      r_lin   <= seq_linear_i;
    end
  end

  logic              sel_q, sel_n, drive_q;
  logic [BASE_W-1:0] base_q;
  logic              ce_ok, p_go, c_go, strobe, wr_any, load, step;
  logic [1:0]        lo;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] addr_c;
  op_e               op_c;

  assign ce_ok  = ~r_sa_n & r_sb & ~r_sc_n;
  assign p_go   = ~r_ps_n & ~r_sa_n;   // processor strobe needs enable A
  assign c_go   = ~r_cs_n & ~p_go;     // processor strobe wins when both low
  assign strobe = p_go | c_go;

  always_comb begin
    op_c  = OP_NONE;
    load  = 1'b0;
    step  = 1'b0;
    sel_n = sel_q;
    if (strobe) begin
      if (ce_ok) begin
        sel_n = 1'b1;
        load  = 1'b1;
        op_c  = (!p_go && wr_any) ? OP_WR : OP_RD;
      end else begin
        sel_n = 1'b0;
      end
    end else if (sel_q) begin
      step = ~r_st_n;
      op_c = wr_any ? OP_WR : OP_RD;
    end
  end

  pbsram_burst u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .linear_i (r_lin),
    .first_i  (r_addr[1:0]),
    .lo_o     (lo)
  );

  pbsram_lane_dec #(.LANES(LANES)) u_dec (
    .allow_i  (op_c == OP_WR),
    .all_n_i  (r_ga_n),
    .byte_n_i (r_bw_n),
    .sel_n_i  (r_ls_n),
    .any_o    (wr_any),
    .we_o     (lane_we)
  );

  assign addr_c = {(load ? r_addr[ADDR_W-1:2] : base_q), lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      base_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      sel_q   <= sel_n;
      drive_q <= (op_c == OP_RD);
      if (load) base_q <= r_addr[ADDR_W-1:2];
    end
  end

  pbsram_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_core (
    .clk_i   (clk_i),
    .re_i    (op_c == OP_RD),
    .we_i    (lane_we),
    .addr_i  (addr_c),
    .wdata_i (r_wdata),
    .rdata_o (rd_data_o)
  );

  assign rd_drive_o = drive_q & (op_c == OP_RD) & ~out_en_n_i;

  assert_pstrb_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_go |-> (lane_we == '0));
  assert_all_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_c == OP_WR && !r_ga_n) |-> (&lane_we));
  assert_lane_pattern_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_c == OP_WR && r_ga_n) |-> (lane_we == ~r_ls_n));
  assert_write_masks_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_we) |-> !rd_drive_o);
  assert_first_after_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_c) == OP_NONE) |-> !rd_drive_o);
  assert_deselect_now_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !ce_ok) |-> !rd_drive_o);
  assert_drive_after_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_drive_o |-> ($past(op_c) == OP_RD));
endmodule

// File: tb/pbsram_top_tb.sv
`timescale 1ns/1ps
module pbsram_top_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic [35:0]   wdata;
  logic          ps_n, cs_n, st_n, sa_n, sb, sc_n, ga_n, bw_n, oe_n, lin;
  logic [3:0]    ls_n;
  logic [35:0]   rd_data;
  logic          rd_drive;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [35:0]   bm [1024];
  logic          m_sel = 1'b0;
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_first = '0, m_cnt = '0;
  logic          m_prev_rd = 1'b0;
  logic [35:0]   m_prev_data = '0;

  always #2.5 clk = ~clk;

  pbsram_top #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_data_i(wdata),
    .pstrb_n_i(ps_n), .cstrb_n_i(cs_n), .burst_step_n_i(st_n),
    .sel_a_n_i(sa_n), .sel_b_i(sb), .sel_c_n_i(sc_n),
    .wr_all_n_i(ga_n), .byte_wr_n_i(bw_n), .lane_sel_n_i(ls_n),
    .out_en_n_i(oe_n), .seq_linear_i(lin),
    .rd_data_o(rd_data), .rd_drive_o(rd_drive)
  );

  task automatic chk(input logic ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] rnd36();
    logic [35:0] v;
    v[31:0]  = $urandom();
    v[35:32] = 4'($urandom());
    return v;
  endfunction

  task automatic idle();
    ps_n = 1; cs_n = 1; st_n = 1; sa_n = 0; sb = 1; sc_n = 0;
    ga_n = 1; bw_n = 1; ls_n = 4'hf; oe_n = 0;
  endtask

  // called at a negedge with inputs set; model computes the expected outputs
  task automatic step(input string tag);
    int op;
    logic ce, pg, cg, wr, exp_drv;
    logic [1:0] lo;
    logic [AW-1:0] ad;
    logic [35:0] nd;
    string t;
    ce = !sa_n && sb && !sc_n;
    pg = !ps_n && !sa_n;
    cg = !cs_n && !pg;
    wr = !ga_n || (!bw_n && (ls_n != 4'hf));
    if (pg || cg) begin
      if (ce) begin
        m_sel = 1; m_base = addr[AW-1:2]; m_first = addr[1:0]; m_cnt = 0;
        op = (pg || !wr) ? 1 : 2;
      end else begin
        m_sel = 0; op = 0;
      end
    end else if (m_sel) begin
      if (!st_n) m_cnt = m_cnt + 2'd1;
      op = wr ? 2 : 1;
    end else op = 0;
    lo = lin ? m_first + m_cnt : m_first ^ m_cnt;
    ad = {m_base, lo};
    exp_drv = m_prev_rd && (op == 1) && !oe_n;
    @(posedge clk);
    @(negedge clk);
    if (tag != "") t = tag;
    else if (op == 2) t = "R6";
    else if (op == 0) t = "R8";
    else if (!m_prev_rd) t = "R7";
    else t = "R12";
    chk(rd_drive === exp_drv, {t, " drive"}, {35'd0, rd_drive}, {35'd0, exp_drv});
    if (m_prev_rd)
      chk(rd_data === m_prev_data, {(tag == "") ? "R1" : tag, " data"}, rd_data, m_prev_data);
    nd = bm[ad];
    if (op == 2)
      for (int k = 0; k < 4; k++)
        if (!ga_n || !ls_n[k]) bm[ad][k*9 +: 9] = wdata[k*9 +: 9];
    m_prev_rd = (op == 1);
    m_prev_data = nd;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    idle(); addr = '0; wdata = '0; lin = 1;
    for (int i = 0; i < 1024; i++) bm[i] = '0;
    repeat (3) @(negedge clk);
    chk(rd_drive === 1'b0, "R13 reset drive", {35'd0, rd_drive}, 36'd0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_drive === 1'b0, "R13 after reset", {35'd0, rd_drive}, 36'd0);

    // preload 0..63 with one-cycle controller-strobe writes, step pin toggling
    for (int a = 0; a < 64; a++) begin
      idle(); cs_n = 0; addr = AW'(a); ga_n = 0; wdata = rnd36(); st_n = a[0];
      step("R3");
    end
    idle(); step("R8"); // stays selected read of last address

    // R1: single read, then hold
    idle(); cs_n = 0; addr = 10'd5; step("R7");
    idle(); step("R1");
    idle(); step("R1");

    // R2: processor strobe with write inputs asserted is a read
    idle(); ps_n = 0; addr = 10'd8; ga_n = 0; wdata = 36'h0AAAAAAAA; step("R2");
    idle(); ga_n = 0; wdata = 36'h123456789; step("R2");
    idle(); cs_n = 0; addr = 10'd8; step("R2");
    idle(); step("R2");
    idle(); step("R2");

    // R5: partial lane writes, and lane write with no lanes selected is a read
    idle(); cs_n = 0; addr = 10'd12; bw_n = 0; ls_n = 4'b1010; wdata = 36'hFFFFFFFFF; step("R5");
    idle(); cs_n = 0; addr = 10'd12; bw_n = 0; ls_n = 4'b1111; wdata = 36'h000000000; step("R5");
    idle(); step("R5");
    idle(); step("R5");
    idle(); cs_n = 0; addr = 10'd13; bw_n = 0; ls_n = 4'b0111; wdata = 36'h155555555; step("R5");
    idle(); cs_n = 0; addr = 10'd13; step("R5");
    idle(); step("R5");

    // R4: all-lane write overrides lane controls
    idle(); cs_n = 0; addr = 10'd14; ga_n = 0; bw_n = 1; ls_n = 4'hf; wdata = 36'h9876FEDC1; step("R4");
    idle(); cs_n = 0; addr = 10'd14; step("R4");
    idle(); step("R4");

    // R10: linear burst from first=1
    lin = 1;
    idle(); ps_n = 0; addr = 10'd17; step("R10");
    for (int i = 0; i < 5; i++) begin idle(); st_n = 0; step("R10"); end
    idle(); step("R10");
    idle(); step("R10");

    // R11: interleaved burst from first=2
    lin = 0;
    idle(); ps_n = 0; addr = 10'd22; step("R11");
    for (int i = 0; i < 5; i++) begin idle(); st_n = 0; step("R11"); end
    lin = 1;

    // R6: write after reads, output enable low
    idle(); bw_n = 0; ls_n = 4'b1110; wdata = 36'h000000011; step("R6");
    idle(); step("R6");

    // R8 then R7: deselect via enable B low, then a fresh read
    idle(); cs_n = 0; sb = 0; step("R8");
    idle(); step("R8");
    idle(); cs_n = 0; addr = 10'd30; step("R7");
    idle(); step("R7");

    // R9: processor strobe ignored while enable A inactive; enable C high deselects
    idle(); ps_n = 0; sa_n = 1; addr = 10'd40; step("R9");
    idle(); step("R9");
    idle(); cs_n = 0; sc_n = 1; addr = 10'd41; step("R9");
    idle(); step("R9");

    // R12: output enable gating
    idle(); cs_n = 0; addr = 10'd33; step("R12");
    idle(); oe_n = 1; step("R12");
    idle(); oe_n = 0; step("R12");
    idle(); oe_n = 1; step("R12");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      idle();
      if (i % 200 == 0) lin = 1'($urandom());
      r = $urandom() % 16;
      ps_n = !(r < 3);
      cs_n = !(r >= 3 && r < 6);
      addr = AW'($urandom() % 64);
      st_n = 1'($urandom());
      sa_n = ($urandom() % 12 == 0);
      sb   = ($urandom() % 12 != 0);
      sc_n = ($urandom() % 12 == 0);
      ga_n = ($urandom() % 4 != 0);
      bw_n = 1'($urandom());
      ls_n = 4'($urandom());
      oe_n = ($urandom() % 5 == 0);
      wdata = rnd36();
      step("");
    end

    finish_run();
  end
endmodule